// File: doc/BRIEF.md
# Receive Word Queue with Per-Word Parity Tags

This block sits behind a serial receiver and holds received words until a host collects them. Each word that enters the queue is stored together with a one-bit tag that records whether its parity check failed. Besides the per-word tags, the block keeps one sticky parity-fail flag. The flag reports that at least one bad word has arrived since it was last cleared. It does not say which word was bad, and it does not say that the word at the head is bad.

The host reads through a single registered port with a two-bit select. The status select returns the flag and the fill state. The extended select returns the tag of the head word and does not remove that word. The data select returns the head word and removes it. The flag is cleared only by a status read followed later by a data read. If a new parity error arrives between those two reads, the sequence is cancelled. A word that arrives while the upstream overrun indication is high, or while the queue is full, is discarded. Such a word never sets the flag.

Top module: `rx_tag_fifo`

## Requirements
- R1: After a synchronous reset, the queue is empty, the flag is 0, and `rd_data` is 0.
- R2: A data read (`rd_sel` = 2) returns the oldest stored word on `rd_data` one cycle after the request and removes that word. Words come out in arrival order.
- R3: An extended read (`rd_sel` = 1) returns the head word's parity tag in bit 0, with all other bits 0. The word is not removed, so the next data read returns that same word.
- R4: A word accepted while `par_en` = 1 and `par_mismatch` = 1 is stored with tag 1 and sets the flag.
- R5: While `par_en` = 0, a word is stored with tag 0 and cannot set the flag, whatever the value of `par_mismatch`.
- R6: A word that arrives while `ovr_in` = 1 is discarded and cannot set the flag.
- R7: A word that arrives while DEPTH words are already stored is discarded, even if a pop happens in the same cycle. Such a word cannot set the flag.
- R8: A data read clears the flag only if a status read has come before it with no data read in between. A data read on its own leaves the flag set.
- R9: A parity error accepted after the status read and before the data read cancels the clear sequence, so the flag stays set.
- R10: A data read from an empty queue returns 0 and leaves the queue contents and fill state unchanged.
- R11: A status read (`rd_sel` = 0) returns the flag in bit 0, "not empty" in bit 1 and "full" in bit 2, with all other bits 0.
- R12: A read with `rd_sel` = 3 returns 0 and has no effect on the queue or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | A received word is present this cycle |
| wr_data | input | DW | Received word |
| par_mismatch | input | 1 | Computed parity disagrees with the received parity bit |
| par_en | input | 1 | Parity checking enabled |
| ovr_in | input | 1 | Upstream overrun condition for this word |
| rd_stb | input | 1 | Host read request |
| rd_sel | input | 2 | 0 status, 1 extended, 2 data, 3 reserved |
| rd_data | output | DW | Registered read result; holds its value between reads |

## Verification
Every read result appears on `rd_data` at the clock edge that samples the request, so it is due exactly one cycle after the request. A word pushed at one edge is visible to a read issued in the following cycle. The driver sets inputs on the falling edge and queues the expected value for each read it issues. The monitor marks a pending result at the rising edge and compares it with the head of the queue at the next falling edge. Effects that must not happen, such as a dropped word, a flag that stays clear, or a pop that did not occur, are checked with status and data reads issued right after the stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_RSVD = 2'd3
  } rsel_e;

  localparam int ST_PF   = 0;
  localparam int ST_NE   = 1;
  localparam int ST_FULL = 2;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wtag,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rtag
);
  logic [DW:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= {wtag, wdata};
  end

  assign rdata = store[raddr][DW-1:0];
  assign rtag  = store[raddr][DW];
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/rxq_flag.sv
module rxq_flag (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic stat_rd,
  input  logic data_rd,
  output logic pf,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pf    <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (err_evt)               pf <= 1'b1;
      else if (data_rd && armed) pf <= 1'b0;

      if (err_evt)      armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;
      else if (data_rd) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          par_mismatch,
  input  logic          par_en,
  input  logic          ovr_in,
  input  logic          rd_stb,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          empty, full;
  logic          accept, err_evt, tag_in;
  logic          stat_rd, ext_rd, data_rd, pop;
  logic          pf_q, armed_q;
  logic [DW-1:0] head_data;
  logic          head_tag;
  logic [DW-1:0] rd_next;
  rsel_e         sel;

  assign sel     = rsel_e'(rd_sel);
  assign accept  = wr_stb && !ovr_in && !full;
  assign tag_in  = par_en && par_mismatch;
  assign err_evt = accept && tag_in;
  assign stat_rd = rd_stb && (sel == SEL_STAT);
  assign ext_rd  = rd_stb && (sel == SEL_EXT);
  assign data_rd = rd_stb && (sel == SEL_DATA);
  assign pop     = data_rd && !empty;

  rxq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .push(accept), .pop(pop),
    .wptr(wptr), .rptr(rptr), .count(cnt), .empty(empty), .full(full)
  );

  rxq_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(accept), .waddr(wptr), .wdata(wr_data), .wtag(tag_in),
    .raddr(rptr), .rdata(head_data), .rtag(head_tag)
  );

  rxq_flag u_flag (
    .clk(clk), .rst(rst), .err_evt(err_evt), .stat_rd(stat_rd),
    .data_rd(data_rd), .pf(pf_q), .armed(armed_q)
  );

  always_comb begin
    rd_next = '0;
    if (stat_rd) begin
      rd_next[ST_PF]   = pf_q;
      rd_next[ST_NE]   = !empty;
      rd_next[ST_FULL] = full;
    end else if (ext_rd) begin
      rd_next[0] = !empty && head_tag;
    end else if (data_rd && !empty) begin
      rd_next = head_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic          par_mismatch,
  input logic          par_en,
  input logic          ovr_in,
  input logic          rd_stb,
  input logic [1:0]    rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          pf,
  input logic          armed,
  input logic [CW-1:0] count
);
  // R4/R5/R6: flag rises only after an enabled mismatch with no overrun
  p_flag_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pf) |-> $past(wr_stb && par_en && par_mismatch && !ovr_in));

  // R7: fill level never exceeds the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R8: flag falls only on a data read that followed a status read
  p_clear_armed_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pf) |-> $past(rd_stb && rd_sel == 2'd2 && armed));

  // R10: an empty data read yields zero and leaves the fill level alone
  p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == 2'd2 && count == '0) |=> (rd_data == '0 && count <= 1));

  // R3: an extended read never lowers the fill level
  p_ext_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == 2'd1) |=> count >= $past(count));

  // R12: a reserved read returns zero
  p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == 2'd3) |=> rd_data == '0);
endmodule

bind rx_tag_fifo rxq_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .par_mismatch(par_mismatch),
  .par_en(par_en), .ovr_in(ovr_in), .rd_stb(rd_stb), .rd_sel(rd_sel),
  .rd_data(rd_data), .pf(pf_q), .armed(armed_q), .count(cnt)
);

// File: tb/rx_tag_fifo_bench.sv
`timescale 1ns/1ps
module rx_tag_fifo_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          par_mismatch = 1'b0;
  logic          par_en = 1'b0;
  logic          ovr_in = 1'b0;
  logic          rd_stb = 1'b0;
  logic [1:0]    rd_sel = 2'd0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cap    = 1'b0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  rx_tag_fifo #(.DW(DW), .DEPTH(4)) u_rx_tag_fifo (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .par_mismatch(par_mismatch), .par_en(par_en), .ovr_in(ovr_in),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always @(posedge clk) cap <= rd_stb;

  // monitor: compare result one cycle after each request
  always @(negedge clk) begin
    if (cap && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic push_word(input logic [DW-1:0] d, input logic mis,
                           input logic pen, input logic ovr);
    wr_stb = 1'b1; wr_data = d; par_mismatch = mis; par_en = pen; ovr_in = ovr;
    @(negedge clk);
    wr_stb = 1'b0; par_mismatch = 1'b0; ovr_in = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [DW-1:0] e, input string t);
    rd_stb = 1'b1; rd_sel = s;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rd_data !== '0) begin
      fails++;
      $display("FAIL R1: rd_data=%h expected=00", rd_data);
    end
    rd(2'd0, 8'h00, "R1 status after reset");
    rd(2'd2, 8'h00, "R10 empty data read");
    rd(2'd0, 8'h00, "R10 still empty");

    push_word(8'hA5, 1'b0, 1'b1, 1'b0);
    push_word(8'h3C, 1'b1, 1'b1, 1'b0);
    push_word(8'h77, 1'b1, 1'b0, 1'b0);
    rd(2'd0, 8'h03, "R4/R11 flag and not-empty");
    rd(2'd1, 8'h00, "R3 head tag clean");
    rd(2'd2, 8'hA5, "R2 oldest first");
    rd(2'd0, 8'h02, "R8 cleared though bad word still queued");
    rd(2'd1, 8'h01, "R3 head tag set");
    rd(2'd1, 8'h01, "R3 tag read twice");
    rd(2'd2, 8'h3C, "R3 no pop on extended read");
    rd(2'd1, 8'h00, "R5 tag zero when parity off");
    rd(2'd2, 8'h77, "R2 order");
    rd(2'd0, 8'h00, "R5 no flag when parity off");

    push_word(8'h22, 1'b1, 1'b1, 1'b0);
    push_word(8'h23, 1'b0, 1'b1, 1'b0);
    rd(2'd2, 8'h22, "R8 data read without status read");
    rd(2'd0, 8'h03, "R8 flag kept");
    rd(2'd2, 8'h23, "R8 armed data read");
    rd(2'd0, 8'h00, "R8 flag cleared");

    push_word(8'h44, 1'b1, 1'b1, 1'b0);
    rd(2'd0, 8'h03, "R4 flag set");
    push_word(8'h45, 1'b1, 1'b1, 1'b0);
    rd(2'd2, 8'h44, "R9 data read after new error");
    rd(2'd0, 8'h03, "R9 flag stays set");
    rd(2'd2, 8'h45, "R9 queued word");
    rd(2'd0, 8'h00, "R9 cleared after fresh sequence");

    push_word(8'h66, 1'b1, 1'b1, 1'b1);
    rd(2'd0, 8'h00, "R6 overrun word dropped no flag");
    rd(2'd2, 8'h00, "R6 nothing stored");

    for (int i = 1; i <= 4; i++) push_word(DW'(i), 1'b0, 1'b1, 1'b0);
    rd(2'd0, 8'h06, "R7/R11 full");
    push_word(8'h99, 1'b1, 1'b1, 1'b0);
    rd(2'd0, 8'h06, "R7 dropped word no flag");
    rd(2'd3, 8'h00, "R12 reserved read");
    for (int i = 1; i <= 4; i++) rd(2'd2, DW'(i), "R7 contents intact");
    rd(2'd2, 8'h00, "R10 drained");
    rd(2'd0, 8'h00, "R12 reserved read had no effect");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule